// File: doc/BRIEF.md
# Conditional-Sum Ling Prefix Adder

This block adds two 64-bit unsigned operands with no carry input and returns the 64-bit sum and a carry-out. Instead of propagating true carries it forms Ling pseudo-carries, where the pseudo-carry into bit i is the generate of bit i-1 ORed with the group generate of the bits below it. A true carry is then the OR-propagate of the bit below ANDed with that pseudo-carry.

Pseudo-carries are produced only at even bit positions (0, 2, ... 62, plus position 64 for the carry-out) by a sparse four-level parallel-prefix tree whose levels merge 4, 2, 4 and 2 inputs in turn. Every two-bit slice of the result is computed twice, once as if its pseudo-carry were 0 and once as if it were 1, and the real pseudo-carry picks one. An optional output register holds the result for timing. With the register on, a result appears at the ports one clock after its operands.

Top module: `ling_adder64`

## Requirements
- R1: `sum` equals the low 64 bits of the unsigned addition `op_a + op_b`, for any operand pair.
- R2: `cout` equals bit 64 of the 65-bit unsigned addition of `op_a` and `op_b`, so it is 1 exactly when the true sum exceeds 2^64-1.
- R3: No carry enters bit 0. All-zero operands give a zero sum with `cout` 0, and all-ones plus zero gives all-ones with `cout` 0.
- R4: For every even bit i from 2 to 62, the true carry into bit i equals (op_a[i-1] OR op_b[i-1]) AND the pseudo-carry at i. A generate at bit i-1 (op_a[i-1] AND op_b[i-1]) forces that pseudo-carry to 1.
- R5: A carry generated at bit 0 ripples through every two-bit slice: all-ones plus one gives a zero sum with `cout` 1.
- R6: Alternating-bit operands add correctly. 0x5555...5 plus 0xAAAA...A gives all-ones with `cout` 0. 0x5555...5 plus itself gives 0xAAAA...A with `cout` 0.
- R7: With the output register enabled (default), `sum` and `cout` show the result of the operands present at the previous rising edge of `clk`. While `rst_n` is low, both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 64 | First addend |
| op_b | input | 64 | Second addend |
| sum | output | 64 | Low 64 bits of the sum |
| cout | output | 1 | Carry out of bit 63 |

## Verification
A wrong pseudo-carry at an even position flips one or both bits of its two-bit slice, and with them every slice above that the carry should reach. With the register on, this shows in `sum` one clock after the operands. Errors in the upper prefix levels only appear when a carry has to cross 8, 32 or more bits, so the full-length chains (all-ones plus one, alternating patterns, a single generate followed by a long propagate run) show them where short random carries would not. A wrong top-level pseudo-carry shows only in `cout`.

// File: rtl/ling_pkg.sv
package ling_pkg;

  // Generate/propagate pair carried through the prefix tree.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Identity element of the merge: no generate, full propagate.
  localparam gp_t GP_IDENT = '{g: 1'b0, p: 1'b1};

  // Merge a higher-order group with the adjacent lower-order group.
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Two-bit sum slice given its pseudo-carry value h.
  // p_below is the OR-propagate of the bit under the slice.
  function automatic logic [1:0] pair_sum(input logic d_hi, input logic d_lo,
                                          input logic g_lo, input logic p_lo,
                                          input logic p_below, input logic h);
    logic c_lo;
    logic c_hi;
    c_lo = p_below & h;
    c_hi = g_lo | (p_lo & c_lo);
    return {d_hi ^ c_hi, d_lo ^ c_lo};
  endfunction

endpackage

// File: rtl/ling_bitcells.sv
module ling_bitcells
  import ling_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output gp_t  [WIDTH-1:0]   ling_pair,
  output logic [WIDTH-1:0]   bit_p,
  output logic [WIDTH-1:0]   bit_d,
  output logic [WIDTH/2-1:0] gen_even
);

  localparam int GROUPS = WIDTH / 2;

  assign bit_p = op_a | op_b;
  assign bit_d = op_a ^ op_b;

  // Ling input pairs: generate of bit j with the propagate of bit j-1.
  // Carry-in is zero, so the lowest pair has no propagate.
  genvar j;
  generate
    for (j = 0; j < WIDTH; j++) begin : g_pair
      assign ling_pair[j].g = op_a[j] & op_b[j];
      if (j == 0) begin : g_lsb
        assign ling_pair[j].p = 1'b0;
      end else begin : g_upper
        assign ling_pair[j].p = op_a[j-1] | op_b[j-1];
      end
    end
    for (j = 0; j < GROUPS; j++) begin : g_even
      assign gen_even[j] = op_a[2*j] & op_b[2*j];
    end
  endgenerate

endmodule

// File: rtl/ling_prefix_level.sv
module ling_prefix_level
  import ling_pkg::*;
#(
  parameter int NODES  = 32,
  parameter int RADIX  = 2,
  parameter int STRIDE = 1
) (
  input  gp_t [NODES-1:0] in_n,
  output gp_t [NODES-1:0] out_n
);

  // Node m merges itself with up to RADIX-1 nodes spaced STRIDE below it.
  always_comb begin
    gp_t acc;
    for (int m = 0; m < NODES; m++) begin
      acc = in_n[m];
      for (int k = 1; k < RADIX; k++) begin
        if (m >= k * STRIDE) begin
          acc = gp_merge(acc, in_n[m - k * STRIDE]);
        end
      end
      out_n[m] = acc;
    end
  end

endmodule

// File: rtl/ling_prefix_tree.sv
module ling_prefix_tree
  import ling_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int RAD1  = 4,
  parameter int RAD2  = 2,
  parameter int RAD3  = 4,
  parameter int RAD4  = 2
) (
  input  gp_t  [WIDTH-1:0]   ling_pair,
  output logic [WIDTH/2:0]   ling_h
);

  localparam int NODES = WIDTH / 2;
  localparam int STR2  = RAD1 / 2;
  localparam int STR3  = (RAD1 * RAD2) / 2;
  localparam int STR4  = (RAD1 * RAD2 * RAD3) / 2;

  gp_t [NODES-1:0] lvl1;
  gp_t [NODES-1:0] lvl2;
  gp_t [NODES-1:0] lvl3;
  gp_t [NODES-1:0] lvl4;

  // Level 1: node m ends at odd bit 2m+1 and spans RAD1 bits.
  always_comb begin
    gp_t acc;
    for (int m = 0; m < NODES; m++) begin
      acc = ling_pair[2*m+1];
      for (int k = 1; k < RAD1; k++) begin
        if (2*m + 1 - k >= 0) begin
          acc = gp_merge(acc, ling_pair[2*m+1-k]);
        end
      end
      lvl1[m] = acc;
    end
  end

  ling_prefix_level #(.NODES(NODES), .RADIX(RAD2), .STRIDE(STR2)) u_lvl2 (
    .in_n (lvl1),
    .out_n(lvl2)
  );

  ling_prefix_level #(.NODES(NODES), .RADIX(RAD3), .STRIDE(STR3)) u_lvl3 (
    .in_n (lvl2),
    .out_n(lvl3)
  );

  ling_prefix_level #(.NODES(NODES), .RADIX(RAD4), .STRIDE(STR4)) u_lvl4 (
    .in_n (lvl3),
    .out_n(lvl4)
  );

  // Pseudo-carry at even bit 2(m+1) is the full group generate up to bit 2m+1.
  assign ling_h[0] = 1'b0;
  genvar m;
  generate
    for (m = 0; m < NODES; m++) begin : g_h
      assign ling_h[m+1] = lvl4[m].g;
    end
  endgenerate

  logic unused_group_p;
  always_comb begin
    unused_group_p = 1'b0;
    for (int n = 0; n < NODES; n++) unused_group_p = unused_group_p ^ lvl4[n].p;
  end

endmodule

// File: rtl/ling_cond_sum.sv
module ling_cond_sum
  import ling_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0]   bit_p,
  input  logic [WIDTH-1:0]   bit_d,
  input  logic [WIDTH/2-1:0] gen_even,
  input  logic [WIDTH/2:0]   ling_h,
  output logic [WIDTH-1:0]   sum_sel,
  output logic               cout_sel
);

  localparam int GROUPS = WIDTH / 2;

  logic [WIDTH-1:0] sum_if0;
  logic [WIDTH-1:0] sum_if1;

  genvar m;
  generate
    for (m = 0; m < GROUPS; m++) begin : g_slice
      logic p_below;
      if (m == 0) begin : g_first
        assign p_below = 1'b0;
      end else begin : g_rest
        assign p_below = bit_p[2*m-1];
      end
      assign sum_if0[2*m+1:2*m] = pair_sum(bit_d[2*m+1], bit_d[2*m], gen_even[m],
                                           bit_p[2*m], p_below, 1'b0);
      assign sum_if1[2*m+1:2*m] = pair_sum(bit_d[2*m+1], bit_d[2*m], gen_even[m],
                                           bit_p[2*m], p_below, 1'b1);
      assign sum_sel[2*m+1:2*m] = ling_h[m] ? sum_if1[2*m+1:2*m] : sum_if0[2*m+1:2*m];
    end
  endgenerate

  assign cout_sel = bit_p[WIDTH-1] & ling_h[GROUPS];

endmodule

// File: rtl/ling_adder64.sv
module ling_adder64
  import ling_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter int RAD1    = 4,
  parameter int RAD2    = 2,
  parameter int RAD3    = 4,
  parameter int RAD4    = 2,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int GROUPS = WIDTH / 2;

  gp_t  [WIDTH-1:0]  ling_pair;
  logic [WIDTH-1:0]  bit_p;
  logic [WIDTH-1:0]  bit_d;
  logic [GROUPS-1:0] gen_even;
  logic [GROUPS:0]   ling_h;
  logic [WIDTH-1:0]  comb_sum;
  logic              comb_cout;

  ling_bitcells #(.WIDTH(WIDTH)) u_cells (
    .op_a     (op_a),
    .op_b     (op_b),
    .ling_pair(ling_pair),
    .bit_p    (bit_p),
    .bit_d    (bit_d),
    .gen_even (gen_even)
  );

  ling_prefix_tree #(
    .WIDTH(WIDTH), .RAD1(RAD1), .RAD2(RAD2), .RAD3(RAD3), .RAD4(RAD4)
  ) u_tree (
    .ling_pair(ling_pair),
    .ling_h   (ling_h)
  );

  ling_cond_sum #(.WIDTH(WIDTH)) u_sel (
    .bit_p   (bit_p),
    .bit_d   (bit_d),
    .gen_even(gen_even),
    .ling_h  (ling_h),
    .sum_sel (comb_sum),
    .cout_sel(comb_cout)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum  <= '0;
          cout <= 1'b0;
        end else begin
          sum  <= comb_sum;
          cout <= comb_cout;
        end
      end
    end else begin : g_comb
      assign sum  = comb_sum;
      assign cout = comb_cout;
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
    end
  endgenerate

endmodule

// File: rtl/ling_adder64_chk.sv
module ling_adder64_chk #(
  parameter int WIDTH   = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [WIDTH/2:0] ling_h
);

  localparam int GROUPS = WIDTH / 2;

  logic [WIDTH:0] ref_now;
  assign ref_now = {1'b0, op_a} + {1'b0, op_b};

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  generate
    if (OUT_REG) begin : g_reg_chk
      // R1
      p_sum_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> sum == $past(ref_now[WIDTH-1:0]));
      // R2
      p_cout_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> cout == $past(ref_now[WIDTH]));
      // R7
      p_reset_clear_r7: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (sum == '0 && cout == 1'b0));
    end else begin : g_comb_chk
      p_sum_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sum == ref_now[WIDTH-1:0]);
      p_cout_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cout == ref_now[WIDTH]);
    end
  endgenerate

  // R2: top pseudo-carry with the top propagate gives the carry-out.
  p_top_pseudo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_a[WIDTH-1] | op_b[WIDTH-1]) & ling_h[GROUPS]) == ref_now[WIDTH]);

  genvar m;
  generate
    for (m = 1; m < GROUPS; m++) begin : g_pos
      // R4: true carry into bit 2m from the arithmetic reference.
      p_ling_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_a[2*m-1] | op_b[2*m-1]) & ling_h[m])
          == (ref_now[2*m] ^ op_a[2*m] ^ op_b[2*m]));
      // R4: a generate just below forces the pseudo-carry.
      p_gen_forces_h_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a[2*m-1] & op_b[2*m-1]) |-> ling_h[m]);
    end
  endgenerate

endmodule

bind ling_adder64 ling_adder64_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op_a  (op_a),
  .op_b  (op_b),
  .sum   (sum),
  .cout  (cout),
  .ling_h(ling_h)
);

// File: tb/ling_adder64_bench.sv
module ling_adder64_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [W-1:0] sum;
  logic         cout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [W:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ling_adder64 u_ling_adder64 (
    .clk  (clk),
    .rst_n(rst_n),
    .op_a (op_a),
    .op_b (op_b),
    .sum  (sum),
    .cout (cout)
  );

  task automatic check65(input logic [W:0] got, input logic [W:0] want, input string req);
    n_checks++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got cout=%0b sum=%h, expected cout=%0b sum=%h",
               req, got[W], got[W-1:0], want[W], want[W-1:0]);
    end
  endtask

  // Compare the result due from the previous vector, then apply a new one.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    @(negedge clk);
    if (exp_q.size() > 0) check65({cout, sum}, exp_q.pop_front(), tag_q.pop_front());
    op_a = a;
    op_b = b;
    exp_q.push_back({1'b0, a} + {1'b0, b});
    tag_q.push_back(req);
  endtask

  task automatic flush();
    @(negedge clk);
    while (exp_q.size() > 0) check65({cout, sum}, exp_q.pop_front(), tag_q.pop_front());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_a  = {W{1'b1}};
    op_b  = {W{1'b1}};
    repeat (3) @(negedge clk);
    // R7: outputs held at zero during reset even with operands applied
    check65({cout, sum}, '0, "R7 reset");
    rst_n = 1'b1;

    step('0, '0, "R3 zero operands");
    step({W{1'b1}}, '0, "R3 all-ones plus zero");
    step({W{1'b1}}, 64'd1, "R5 full carry chain");
    step(64'd1, {W{1'b1}}, "R5 full carry chain swapped");
    step({W{1'b1}}, {W{1'b1}}, "R2 all-ones doubled");
    step({32{2'b01}}, {32{2'b10}}, "R6 alternating complement");
    step({32{2'b01}}, {32{2'b01}}, "R6 alternating doubled");
    step({32{2'b10}}, {32{2'b10}}, "R2 alternating carry-out");
    step(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R2 top bits only");
    step(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, "R5 chain to bit 63");

    // R4: a generate at each odd bit below a run of propagates up to the top
    for (int m = 1; m < W/2; m++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = {W{1'b1}} << (2*m - 1);
      b = 64'd1 << (2*m - 1);
      step(a, b, $sformatf("R4 generate at bit %0d", 2*m-1));
    end

    // R4: a propagate run ending at an even bit with the generate below it
    for (int m = 1; m < W/2; m++) begin
      logic [W-1:0] a;
      a = (64'd1 << (2*m)) - 64'd1;
      step(a, 64'd1, $sformatf("R4 chain to bit %0d", 2*m));
    end

    // R1: random operands, back to back every clock
    for (int i = 0; i < 400; i++) begin
      step({$urandom(), $urandom()}, {$urandom(), $urandom()}, "R1 random");
    end
    flush();

    // R7: reset mid-stream clears registered result
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check65({cout, sum}, '0, "R7 reset again");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule